// File: doc/BRIEF.md
# Nested Priority Interrupt Vector Controller

This block arbitrates among up to 32 interrupt request sources and drives one active-high request line to a processor. Each source carries a three-bit priority and a handler address (its vector). A source-conditioning stage upstream supplies a vector of pending flags, and an enable mask selects which of them may compete. When the processor reads the acknowledge register it receives the vector of the winning source. That read also makes the winner's priority the new current level, and this takes the request line low.

Interrupts can nest. When a source with a higher priority becomes pending while another is in service, the request line goes high again. The next acknowledge saves the interrupted level on a last-in first-out stack before it switches to the new level. A write to the end-of-service register restores the most recently saved level. When the stack is empty, that write returns the controller to idle. An acknowledge with nothing eligible returns a programmable spurious vector and changes no state.

All registers sit on a simple single-cycle register bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source i has a priority register at address 0x00+i that keeps wdata bits [2:0] and reads back zero-extended, and a vector register at address 0x20+i that holds a full 32-bit word.
- R2: Among eligible pending sources, the one with the numerically largest priority wins (7 highest, 0 lowest). On equal priority the lowest source index wins.
- R3: The enable mask at address 0x40 has bit i = 1 to let source i compete. A pending source whose mask bit is 0 neither raises the request line nor wins an acknowledge.
- R4: A read of the acknowledge register at address 0x41 returns the vector of the source that wins at the moment of the read.
- R5: The request line is high exactly when some enabled pending source has a priority strictly above the current level. The idle level counts as below 0.
- R6: An acknowledge while the request line is high sets the current level to the winner's priority, so the request line is low in the next cycle unless the pending inputs change.
- R7: If a higher-priority source appears after the request line rose but before any acknowledge while idle, the acknowledge returns the newer vector and saves nothing on the stack.
- R8: An acknowledge while a level is already in service and a higher level is eligible saves the current level on the stack, which holds 8 entries, before it switches. Seven nested switches fit.
- R9: A write to the end-of-service register at address 0x42 restores the most recently saved level when the stack is non-empty, and otherwise returns to idle.
- R10: An acknowledge while the request line is low returns the spurious vector held at address 0x43 and leaves the current level and the stack unchanged.
- R11: After reset the controller is idle, the request line is low, the stack is empty, and all priority, vector, mask and spurious registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| addr_i | input | 7 | Register address |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; at address 0x41 it is the acknowledge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pend_i | input | NUM_SRC | Pending flags from the conditioning stage |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong current level shows up on the request line in the very next cycle, because the line compares pending priorities against that level. A corrupted stack entry stays hidden until an end-of-service write pops it, which can be several interrupts later. For that reason the bench looks at the request line right after every end-of-service write, with the pending inputs chosen so that an idle state and each possible restored level give different values. Arbitration faults appear directly in the vector returned by the acknowledge. The bench sweeps every pending pattern under several priority layouts and every mask value to catch them.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 7;

    // address bank in addr[6:5]
    typedef enum logic [1:0] {
        BANK_PRIO = 2'd0,
        BANK_VEC  = 2'd1,
        BANK_CTRL = 2'd2
    } bank_e;

    // control register in addr[1:0] within BANK_CTRL
    typedef enum logic [1:0] {
        CTL_MASK = 2'd0,
        CTL_ACK  = 2'd1,
        CTL_EOI  = 2'd2,
        CTL_SPUR = 2'd3
    } ctl_e;

    typedef struct packed {
        logic              active;
        logic [PRIO_W-1:0] lvl;
    } level_t;
endpackage

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           found_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [PRIO_W-1:0]              prio_o
);
    // strict compare keeps the lowest index on ties
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!found_o || (prio_i[i] > prio_o))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_regfile.sv
module prio_irq_regfile
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [NUM_SRC-1:0][DATA_W-1:0] vec_o,
    output logic [NUM_SRC-1:0]             mask_o,
    output logic [DATA_W-1:0]              spur_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0][DATA_W-1:0] vec;
        logic [NUM_SRC-1:0]             mask;
        logic [DATA_W-1:0]              spur;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en_i) begin
            case (addr_i[6:5])
                BANK_PRIO: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        if (addr_i[4:0] == 5'(i)) rf_d.prio[i] = wdata_i[PRIO_W-1:0];
                    end
                end
                BANK_VEC: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        if (addr_i[4:0] == 5'(i)) rf_d.vec[i] = wdata_i;
                    end
                end
                BANK_CTRL: begin
                    case (addr_i[1:0])
                        CTL_MASK: rf_d.mask = wdata_i[NUM_SRC-1:0];
                        CTL_SPUR: rf_d.spur = wdata_i;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rf_q <= '0;
        else         rf_q <= rf_d;
    end

    assign prio_o = rf_q.prio;
    assign vec_o  = rf_q.vec;
    assign mask_o = rf_q.mask;
    assign spur_o = rf_q.spur;
endmodule

// File: rtl/prio_irq_lvlstack.sv
module prio_irq_lvlstack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              take_i,
    input  logic [PRIO_W-1:0] new_lvl_i,
    input  logic              eoi_i,
    output level_t            cur_o,
    output logic [SP_W-1:0]   sp_o
);
    typedef struct packed {
        level_t                  cur;
        level_t [DEPTH-1:0]      stk;
        logic   [SP_W-1:0]       sp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            if (st_q.cur.active && (st_q.sp < SP_W'(DEPTH))) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (st_q.sp == SP_W'(k)) st_d.stk[k] = st_q.cur;
                end
                st_d.sp = st_q.sp + 1'b1;
            end
            st_d.cur.active = 1'b1;
            st_d.cur.lvl    = new_lvl_i;
        end else if (eoi_i) begin
            if (st_q.sp != '0) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (st_q.sp == SP_W'(k + 1)) st_d.cur = st_q.stk[k];
                end
                st_d.sp = st_q.sp - 1'b1;
            end else begin
                st_d.cur = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cur_o = st_q.cur;
    assign sp_o  = st_q.sp;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [6:0]         addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               irq_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int DEPTH = 1 << PRIO_W;
    localparam int SP_W  = $clog2(DEPTH + 1);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
    logic [NUM_SRC-1:0][DATA_W-1:0] vec_w;
    logic [NUM_SRC-1:0]             mask_w;
    logic [DATA_W-1:0]              spur_w;
    logic                           found_w;
    logic [IDX_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_prio;
    level_t                         cur_w;
    logic [SP_W-1:0]                sp_w;
    logic                           hit_w;
    logic                           ack_w;
    logic                           take_w;
    logic                           eoi_w;
    logic                           is_ctrl;

    prio_irq_regfile #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .prio_o  (prio_w),
        .vec_o   (vec_w),
        .mask_o  (mask_w),
        .spur_o  (spur_w)
    );

    prio_irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .req_i   (pend_i & mask_w),
        .prio_i  (prio_w),
        .found_o (found_w),
        .idx_o   (win_idx),
        .prio_o  (win_prio)
    );

    prio_irq_lvlstack #(.DEPTH(DEPTH)) u_lvl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .take_i    (take_w),
        .new_lvl_i (win_prio),
        .eoi_i     (eoi_w),
        .cur_o     (cur_w),
        .sp_o      (sp_w)
    );

    assign is_ctrl = (addr_i[6:5] == BANK_CTRL);
    assign hit_w   = found_w && (!cur_w.active || (win_prio > cur_w.lvl));
    assign ack_w   = rd_en_i && is_ctrl && (addr_i[1:0] == CTL_ACK);
    assign take_w  = ack_w && hit_w;
    assign eoi_w   = wr_en_i && !rd_en_i && is_ctrl && (addr_i[1:0] == CTL_EOI);
    assign irq_o   = hit_w;

    always_comb begin
        rdata_o = '0;
        case (addr_i[6:5])
            BANK_PRIO: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (addr_i[4:0] == 5'(i)) rdata_o = DATA_W'(prio_w[i]);
                end
            end
            BANK_VEC: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (addr_i[4:0] == 5'(i)) rdata_o = vec_w[i];
                end
            end
            BANK_CTRL: begin
                case (addr_i[1:0])
                    CTL_MASK: rdata_o = DATA_W'(mask_w);
                    CTL_ACK:  rdata_o = hit_w ? vec_w[win_idx] : spur_w;
                    CTL_SPUR: rdata_o = spur_w;
                    default:  rdata_o = '0;
                endcase
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 8,
    localparam int SP_W   = $clog2(DEPTH + 1)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               irq,
    input logic               ack,
    input logic               eoi,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [DATA_W-1:0]  rdata,
    input logic [DATA_W-1:0]  spur,
    input logic               cur_active,
    input logic [PRIO_W-1:0]  cur_lvl,
    input logic [SP_W-1:0]    sp
);
    // R5
    irq_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq |-> ((pend & mask) != '0));

    // R6
    ack_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack && irq) |=> (!irq || (pend != $past(pend))));

    // R6
    ack_enters_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack && irq) |=> cur_active);

    // R7
    idle_ack_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack && irq && !cur_active) |=> (sp == $past(sp)));

    // R8
    nested_ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack && irq && cur_active) |=> (sp == $past(sp) + 1'b1));

    // R8
    stack_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sp <= SP_W'(DEPTH));

    // R9
    eoi_empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi && !ack && (sp == '0)) |=> !cur_active);

    // R10
    spurious_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack && !irq) |=> ($stable(cur_active) && $stable(cur_lvl) && $stable(sp)));

    // R10
    spurious_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack && !irq) |-> (rdata == spur));
endmodule

bind prio_irq_ctrl prio_irq_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq        (irq_o),
    .ack        (ack_w),
    .eoi        (eoi_w),
    .pend       (pend_i),
    .mask       (mask_w),
    .rdata      (rdata_o),
    .spur       (spur_w),
    .cur_active (cur_w.active),
    .cur_lvl    (cur_w.lvl),
    .sp         (sp_w)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int NS = 8;
    localparam logic [6:0] A_MASK = 7'h40;
    localparam logic [6:0] A_ACK  = 7'h41;
    localparam logic [6:0] A_EOI  = 7'h42;
    localparam logic [6:0] A_SPUR = 7'h43;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [6:0]    addr_i = '0;
    logic          wr_en_i = 1'b0;
    logic          rd_en_i = 1'b0;
    logic [31:0]   wdata_i = '0;
    logic [31:0]   rdata_o;
    logic [NS-1:0] pend_i = '0;
    logic          irq_o;

    int nchk = 0;
    int nerr = 0;
    int prio_m [NS];

    always #4 clk_i = ~clk_i;

    prio_irq_ctrl #(.NUM_SRC(NS), .DATA_W(32)) uut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .pend_i  (pend_i),
        .irq_o   (irq_o)
    );

    function automatic logic [31:0] vec_of(int i);
        return 32'hA000_0000 | (32'(i) << 4) | 32'h5;
    endfunction

    function automatic int model_win(logic [NS-1:0] p, logic [NS-1:0] m);
        int w  = -1;
        int bp = -1;
        for (int i = 0; i < NS; i++) begin
            if (p[i] && m[i] && prio_m[i] > bp) begin
                w  = i;
                bp = prio_m[i];
            end
        end
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk_i);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk_i);
        addr_i = a; rd_en_i = 1'b1;
        #1 d = rdata_o;
        @(negedge clk_i);
        rd_en_i = 1'b0;
        #1;
    endtask

    task automatic set_pend(logic [NS-1:0] v);
        @(negedge clk_i);
        pend_i = v;
        #1;
    endtask

    task automatic set_cfg(int k);
        for (int i = 0; i < NS; i++) begin
            case (k)
                0:       prio_m[i] = i % 4;
                1:       prio_m[i] = 7 - i;
                default: prio_m[i] = (i * 3 + 1) % 8;
            endcase
            bus_wr(7'(i), 32'(prio_m[i]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        nerr++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        #1;

        // R11 reset state
        chk("R11 irq", 32'(irq_o), 0);
        bus_rd(A_ACK, d);   chk("R11 ack spurious", d, 0);
        bus_rd(7'h03, d);   chk("R11 prio", d, 0);
        bus_rd(7'h25, d);   chk("R11 vec", d, 0);
        bus_rd(A_MASK, d);  chk("R11 mask", d, 0);
        bus_rd(A_SPUR, d);  chk("R11 spur", d, 0);

        // R1 register readback
        bus_wr(7'h02, 32'hFFFF_FFFD);
        bus_rd(7'h02, d);   chk("R1 prio field", d, 32'h5);
        for (int i = 0; i < NS; i++) bus_wr(7'h20 + 7'(i), vec_of(i));
        for (int i = 0; i < NS; i++) begin
            bus_rd(7'h20 + 7'(i), d);
            chk("R1 vec readback", d, vec_of(i));
        end
        bus_wr(A_MASK, 32'hFF);

        // R2 R4 R5 R6 sweep over every pending pattern and three layouts
        for (int k = 0; k < 3; k++) begin
            set_cfg(k);
            for (int i = 0; i < NS; i++) begin
                bus_rd(7'(i), d);
                chk("R1 prio readback", d, 32'(prio_m[i]));
            end
            for (int p = 1; p < 256; p++) begin
                set_pend(p[NS-1:0]);
                w = model_win(p[NS-1:0], 8'hFF);
                chk("R5 irq idle", 32'(irq_o), 1);
                bus_rd(A_ACK, d);
                chk("R2 R4 winner vector", d, vec_of(w));
                chk("R6 irq after ack", 32'(irq_o), 0);
                bus_wr(A_EOI, 0);
            end
        end

        // R2 explicit tie: sources 1 and 5 share level 1
        set_cfg(0);
        set_pend(8'h22);
        bus_rd(A_ACK, d);   chk("R2 tie lowest index", d, vec_of(1));
        bus_wr(A_EOI, 0);

        // R3 every mask value with all sources pending
        set_cfg(1);
        set_pend(8'hFF);
        for (int m = 0; m < 256; m++) begin
            bus_wr(A_MASK, 32'(m));
            w = model_win(8'hFF, m[NS-1:0]);
            chk("R3 irq under mask", 32'(irq_o), (m != 0) ? 1 : 0);
            bus_rd(A_ACK, d);
            chk("R3 masked winner", d, (m != 0) ? vec_of(w) : 32'h0);
            bus_wr(A_EOI, 0);
        end
        bus_wr(A_MASK, 32'hFF);

        // R10 spurious read while idle and while in service
        bus_wr(A_SPUR, 32'hDEAD_BEEF);
        set_pend(0);
        bus_rd(A_ACK, d);   chk("R10 idle spurious", d, 32'hDEAD_BEEF);
        chk("R10 irq stays low", 32'(irq_o), 0);
        set_pend(8'h20);                 // src5 level 2
        bus_rd(A_ACK, d);   chk("R4 src5", d, vec_of(5));
        set_pend(8'h60);                 // add src6 level 1
        chk("R5 lower not raised", 32'(irq_o), 0);
        bus_rd(A_ACK, d);   chk("R10 in-service spurious", d, 32'hDEAD_BEEF);
        set_pend(8'h20);
        bus_wr(A_EOI, 0);
        chk("R10 R9 no state change then idle", 32'(irq_o), 1);
        bus_rd(A_ACK, d);   bus_wr(A_EOI, 0);

        // R7 upgrade before acknowledge: no push
        set_pend(8'h40);                 // src6 level 1
        chk("R7 irq raised", 32'(irq_o), 1);
        set_pend(8'h44);                 // add src2 level 5
        bus_rd(A_ACK, d);   chk("R7 newer vector", d, vec_of(2));
        chk("R7 irq low", 32'(irq_o), 0);
        set_pend(8'h40);
        bus_wr(A_EOI, 0);
        chk("R7 eoi returns idle", 32'(irq_o), 1);
        bus_rd(A_ACK, d);   bus_wr(A_EOI, 0);
        set_pend(0);

        // R8 R9 single nesting
        set_pend(8'h40);
        bus_rd(A_ACK, d);   chk("R8 first level", d, vec_of(6));
        set_pend(8'h44);
        chk("R8 irq reraised", 32'(irq_o), 1);
        bus_rd(A_ACK, d);   chk("R8 nested vector", d, vec_of(2));
        chk("R8 irq low", 32'(irq_o), 0);
        set_pend(8'h40);
        bus_wr(A_EOI, 0);
        chk("R9 popped to level 1", 32'(irq_o), 0);
        bus_wr(A_EOI, 0);
        chk("R9 empty pop idle", 32'(irq_o), 1);
        bus_rd(A_ACK, d);   bus_wr(A_EOI, 0);
        set_pend(0);

        // R8 R9 full depth: level 0 up to level 7
        for (int j = NS - 1; j >= 0; j--) begin
            set_pend(pend_i | NS'(1 << j));
            chk("R8 deep irq", 32'(irq_o), 1);
            bus_rd(A_ACK, d);
            chk("R8 deep vector", d, vec_of(j));
            chk("R8 deep irq low", 32'(irq_o), 0);
        end
        for (int j = 0; j < NS - 1; j++) begin
            set_pend(pend_i & ~NS'(1 << j));
            bus_wr(A_EOI, 0);
            chk("R9 deep pop", 32'(irq_o), 0);
        end
        bus_wr(A_EOI, 0);
        chk("R9 deep to idle", 32'(irq_o), 1);
        bus_rd(A_ACK, d);   chk("R4 last source", d, vec_of(7));

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule